// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Core

This block is a synchronous memory with one port that only reads and one that only writes, sharing a single address bus. Each memory entry holds a pair of words, and every access moves that whole pair. The double-rate input and output clocks are modelled as two alternating phases of one internal clock. The block exposes the phase on `phase_p`: a cycle with `phase_p` high ends in the positive-phase edge, and the next cycle ends in the negative-phase edge. Phase tracking restarts at reset.

On a positive-phase edge the block samples both port selects. If the read port is selected, the address bus is taken as the read address. If the write port is selected, the first write word and its lane enables are taken as well. On the following negative-phase edge the address bus carries the write address, together with the second write word and its lane enables. Write bursts are committed to the array one positive edge later. A read that targets an address still waiting to be committed has that write forwarded to it, lane by lane, so it always returns the newest data. A static strap selects between a latency of one and a half input-clock periods and a shorter legacy latency of one period.

Read data leaves as a two-beat stream qualified by `rvalid`. The read stream has no ready input and cannot be back-pressured: once a read is accepted, its beats appear at fixed cycles, and the receiver must take each beat in the cycle where `rvalid` is high. In this model the high-impedance output state is shown as `rvalid` low with `rdata` held at zero.

Top module: `burst2_sram`

## Requirements
- R1: After reset, `rvalid` is 0, `rdata` is 0 and `phase_p` is 1, so the first edge after reset is a positive-phase edge.
- R2: A read starts when `rd_sel_n` is 0 at a positive-phase edge, and `addr` at that edge becomes the read address. `rd_sel_n` and `addr` have no read effect on negative-phase edges.
- R3: A write starts when `wr_sel_n` is 0 at a positive-phase edge, and `wdata`/`lane_n` at that edge give word 0. At the next negative-phase edge, `addr` is the write address and `wdata`/`lane_n` give word 1. `wr_sel_n` is ignored on negative-phase edges.
- R4: Every read produces two beats with `rvalid` high in two consecutive cycles: first word 0 (offset +0), then word 1 (offset +1). Reads on back-to-back positive edges give an unbroken valid stream.
- R5: `lane_n` is active low. Lane i covers bits [i*LW +: LW], where LW = DW/LANES; for the default 18-bit word, lane 0 is bits [8:0] and lane 1 is bits [17:9]. Each word has its own lane enables, and a lane whose enable is 1 keeps its stored value.
- R6: With `lat_legacy` = 0, word 0 of a read started at positive edge E is on `rdata` in the cycle after edge E+3, and word 1 is on `rdata` in the cycle after edge E+4.
- R7: With `lat_legacy` = 1, word 0 appears in the cycle after edge E+2, and word 1 in the cycle after edge E+3.
- R8: A read started at positive edge E returns data that includes every write started at a positive edge up to and including E. This includes a write to the same address started at E itself.
- R9: When `rvalid` is 0, `rdata` is all zeros. A positive edge without a read produces no valid beat in the two cycles its read would have used.
- R10: A read and a write may start at the same positive edge, to different addresses, and neither affects the other.
- R11: A positive edge with `wr_sel_n` = 1 leaves the array unchanged, whatever is on `addr`, `wdata` and `lane_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; alternate edges model the positive and negative input-clock edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_legacy | input | 1 | Static strap: 1 selects the shorter legacy read latency |
| phase_p | output | 1 | High in cycles that end in a positive-phase edge |
| rd_sel_n | input | 1 | Read select, active low, sampled on positive-phase edges |
| wr_sel_n | input | 1 | Write select, active low, sampled on positive-phase edges |
| addr | input | AW | Shared address: read address on positive phase, write address on negative phase |
| wdata | input | DW | Write word 0 on positive phase, word 1 on negative phase |
| lane_n | input | LANES | Active-low lane write enables for the word currently on `wdata` |
| rdata | output | DW | Read beat data, zero when not valid |
| rvalid | output | 1 | Read beat valid |

## Verification
The interesting overlap is a read and a write landing on the same positive edge, or a read arriving one positive edge after a write, while that write's burst is still waiting to be committed. The bench provokes this in directed cases with full and partial lane masks on the same address. It also provokes it in a random stream that confines addresses to a few locations so that hits are frequent. Every read is judged by a bench-side copy of the array that applies each write before computing the data for a read started on the same edge. The bench then expects the two beats in the exact cycles set by the latency strap.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  typedef enum logic {PH_POS = 1'b0, PH_NEG = 1'b1} phase_e;
endpackage

// File: rtl/b2s_phase.sv
module b2s_phase (
  input  logic              clk,
  input  logic              rst_n,
  output b2s_pkg::phase_e   ph
);
  import b2s_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_POS;
    else        ph <= (ph == PH_POS) ? PH_NEG : PH_POS;
  end
endmodule

// File: rtl/b2s_wcap.sv
module b2s_wcap #(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  b2s_pkg::phase_e      ph,
  input  logic                 wr_sel_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [LANES-1:0]     lane_n,
  output logic                 commit,
  output logic [AW-1:0]        c_addr,
  output logic [DW-1:0]        c_w0,
  output logic [DW-1:0]        c_w1,
  output logic [LANES-1:0]     c_en0,
  output logic [LANES-1:0]     c_en1
);
  import b2s_pkg::*;
  logic             go;
  logic             pend_v;
  logic [DW-1:0]    w0_q;
  logic [LANES-1:0] en0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go     <= 1'b0;
      pend_v <= 1'b0;
      w0_q   <= '0;
      en0_q  <= '0;
      c_addr <= '0;
      c_w0   <= '0;
      c_w1   <= '0;
      c_en0  <= '0;
      c_en1  <= '0;
    end else if (ph == PH_POS) begin
      // pending burst commits on this edge; new burst may start
      pend_v <= 1'b0;
      go     <= !wr_sel_n;
      if (!wr_sel_n) begin
        w0_q  <= wdata;
        en0_q <= ~lane_n;
      end
    end else begin
      if (go) begin
        pend_v <= 1'b1;
        c_addr <= addr;
        c_w0   <= w0_q;
        c_en0  <= en0_q;
        c_w1   <= wdata;
        c_en1  <= ~lane_n;
      end
      go <= 1'b0;
    end
  end

  assign commit = pend_v && (ph == PH_POS);
endmodule

// File: rtl/b2s_array.sv
module b2s_array #(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wd0,
  input  logic [DW-1:0]    wd1,
  input  logic [LANES-1:0] wen0,
  input  logic [LANES-1:0] wen1,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rd0,
  output logic [DW-1:0]    rd1
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / LANES;

  logic [DW-1:0] bank0 [DEPTH];
  logic [DW-1:0] bank1 [DEPTH];
  logic [DW-1:0] cur0, cur1, nw0, nw1;

  assign cur0 = bank0[waddr];
  assign cur1 = bank1[waddr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nw0[g*LW +: LW] = wen0[g] ? wd0[g*LW +: LW] : cur0[g*LW +: LW];
    assign nw1[g*LW +: LW] = wen1[g] ? wd1[g*LW +: LW] : cur1[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      bank0[waddr] <= nw0;
      bank1[waddr] <= nw1;
    end
  end

  assign rd0 = bank0[raddr];
  assign rd1 = bank1[raddr];
endmodule

// File: rtl/b2s_rdpath.sv
module b2s_rdpath #(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  b2s_pkg::phase_e  ph,
  input  logic             legacy,
  input  logic             rd_sel_n,
  input  logic [AW-1:0]    addr,
  output logic [AW-1:0]    raddr,
  input  logic [DW-1:0]    arr0,
  input  logic [DW-1:0]    arr1,
  input  logic             fwd_v,
  input  logic [AW-1:0]    fwd_addr,
  input  logic [DW-1:0]    fwd_w0,
  input  logic [DW-1:0]    fwd_w1,
  input  logic [LANES-1:0] fwd_en0,
  input  logic [LANES-1:0] fwd_en1,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  import b2s_pkg::*;
  localparam int LW = DW / LANES;

  logic          go;
  logic [AW-1:0] raddr_q;
  logic          fetch, hit;
  logic [DW-1:0] f0, f1;
  logic [DW-1:0] stage_d, hold_d;
  logic          stage_v, hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go      <= 1'b0;
      raddr_q <= '0;
    end else if (ph == PH_POS) begin
      go <= !rd_sel_n;
      if (!rd_sel_n) raddr_q <= addr;
    end
  end

  assign raddr = raddr_q;
  assign fetch = go && (ph == PH_POS);
  assign hit   = fwd_v && (fwd_addr == raddr_q);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign f0[g*LW +: LW] = (hit && fwd_en0[g]) ? fwd_w0[g*LW +: LW] : arr0[g*LW +: LW];
    assign f1[g*LW +: LW] = (hit && fwd_en1[g]) ? fwd_w1[g*LW +: LW] : arr1[g*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      rvalid  <= 1'b0;
      stage_d <= '0;
      stage_v <= 1'b0;
      hold_d  <= '0;
      hold_v  <= 1'b0;
    end else if (ph == PH_POS) begin
      hold_d <= f1;
      hold_v <= fetch;
      if (legacy) begin
        rdata   <= fetch ? f0 : '0;
        rvalid  <= fetch;
        stage_v <= 1'b0;
      end else begin
        rdata   <= hold_v ? hold_d : '0;
        rvalid  <= hold_v;
        stage_d <= f0;
        stage_v <= fetch;
      end
    end else begin
      if (legacy) begin
        rdata  <= hold_v ? hold_d : '0;
        rvalid <= hold_v;
        hold_v <= 1'b0;
      end else begin
        rdata   <= stage_v ? stage_d : '0;
        rvalid  <= stage_v;
        stage_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram #(
  parameter int AW    = 4,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_legacy,
  output logic             phase_p,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  import b2s_pkg::*;

  phase_e           ph;
  logic             commit;
  logic [AW-1:0]    c_addr, raddr;
  logic [DW-1:0]    c_w0, c_w1, arr0, arr1;
  logic [LANES-1:0] c_en0, c_en1;

  b2s_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  b2s_wcap #(.AW(AW), .DW(DW), .LANES(LANES)) u_wcap (
    .clk(clk), .rst_n(rst_n), .ph(ph), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .lane_n(lane_n), .commit(commit), .c_addr(c_addr),
    .c_w0(c_w0), .c_w1(c_w1), .c_en0(c_en0), .c_en1(c_en1));

  b2s_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
    .clk(clk), .we(commit), .waddr(c_addr), .wd0(c_w0), .wd1(c_w1),
    .wen0(c_en0), .wen1(c_en1), .raddr(raddr), .rd0(arr0), .rd1(arr1));

  b2s_rdpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .ph(ph), .legacy(lat_legacy), .rd_sel_n(rd_sel_n),
    .addr(addr), .raddr(raddr), .arr0(arr0), .arr1(arr1), .fwd_v(commit),
    .fwd_addr(c_addr), .fwd_w0(c_w0), .fwd_w1(c_w1), .fwd_en0(c_en0),
    .fwd_en1(c_en1), .rdata(rdata), .rvalid(rvalid));

  assign phase_p = (ph == PH_POS);
endmodule

// File: rtl/b2s_chk.sv
module b2s_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lat_legacy,
  input logic          phase_p,
  input logic          rd_sel_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0)); // R9

  AST_BURST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid); // R4

  AST_NORMAL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_p && !rd_sel_n && !lat_legacy) |-> ##4 rvalid); // R6

  AST_LEGACY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_p && !rd_sel_n && lat_legacy) |-> ##3 rvalid); // R7

  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_p && rd_sel_n && !lat_legacy) |-> ##4 !rvalid); // R9
endmodule

bind burst2_sram b2s_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_legacy(lat_legacy), .phase_p(phase_p),
  .rd_sel_n(rd_sel_n), .rvalid(rvalid), .rdata(rdata));

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;
  localparam int AW = 4, DW = 18, LANES = 2, LW = 9, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, lat_legacy = 1'b0;
  logic phase_p, rd_sel_n = 1'b1, wr_sel_n = 1'b1, rvalid;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [LANES-1:0] lane_n = '1;

  burst2_sram #(.AW(AW), .DW(DW), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .lat_legacy(lat_legacy), .phase_p(phase_p),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata),
    .lane_n(lane_n), .rdata(rdata), .rvalid(rvalid));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, ec = 0;
  bit mon_on = 0, done = 0;
  logic [DW-1:0] m0 [DEPTH];
  logic [DW-1:0] m1 [DEPTH];
  logic          exp_v [64];
  logic [DW-1:0] exp_d [64];
  string         exp_t [64];
  string         cur_tag = "R3";

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] o, logic [DW-1:0] n,
                                         logic [LANES-1:0] ln);
    for (int l = 0; l < LANES; l++) if (!ln[l]) o[l*LW +: LW] = n[l*LW +: LW];
    return o;
  endfunction

  task automatic fail(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nerr++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // Output monitor: samples 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    ec++;
    if (mon_on) begin
      int s;
      s = ec % 64;
      nchk++;
      if (rvalid !== exp_v[s])
        fail(exp_v[s] ? exp_t[s] : "R9", "rvalid", {17'd0, rvalid}, {17'd0, exp_v[s]});
      else if (exp_v[s] && rdata !== exp_d[s])
        fail(exp_t[s], "rdata", rdata, exp_d[s]);
      else if (!exp_v[s] && rdata !== '0)
        fail("R9", "idle rdata", rdata, '0);
      exp_v[s] = 1'b0;
    end
  end

  // One positive/negative phase pair, starting at a falling edge with phase_p high
  task automatic kc(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                    logic [DW-1:0] d0, logic [LANES-1:0] l0,
                    logic [DW-1:0] d1, logic [LANES-1:0] l1);
    int lat, s;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; wdata = d0; lane_n = l0;
    if (wr) begin
      m0[wa] = mrg(m0[wa], d0, l0);
      m1[wa] = mrg(m1[wa], d1, l1);
    end
    if (rd) begin
      lat = lat_legacy ? 3 : 4;
      s = (ec + lat) % 64;
      exp_v[s] = 1'b1; exp_d[s] = m0[ra]; exp_t[s] = cur_tag;
      s = (ec + lat + 1) % 64;
      exp_v[s] = 1'b1; exp_d[s] = m1[ra]; exp_t[s] = cur_tag;
    end
    @(negedge clk);
    // negative phase: selects are ignored (R2, R3), addr is the write address only
    rd_sel_n = 1'($urandom); wr_sel_n = 1'($urandom);
    addr = wr ? wa : AW'($urandom);
    wdata = d1; lane_n = l1;
    @(negedge clk);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++)
      kc(0, AW'($urandom), 0, AW'($urandom), DW'($urandom), LANES'($urandom),
         DW'($urandom), LANES'($urandom));
  endtask

  task automatic do_reset(bit leg);
    mon_on = 0;
    @(negedge clk);
    rst_n = 1'b0; lat_legacy = leg; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    nchk++;
    if (rvalid !== 1'b0 || rdata !== '0 || phase_p !== 1'b1)
      fail("R1", "reset state", rdata, '0);
    mon_on = 1;
  endtask

  task automatic run_mode(bit leg);
    logic [DW-1:0] a, b;
    do_reset(leg);
    cur_tag = "R3";
    for (int i = 0; i < DEPTH; i++)
      kc(0, 0, 1, AW'(i), DW'($urandom), '0, DW'($urandom), '0);
    for (int i = 0; i < DEPTH; i++) kc(1, AW'(i), 0, 0, 0, '1, 0, '1);
    nop(3);
    // R8: read and write of the same address on the same edge, then next edge
    cur_tag = "R8";
    a = DW'($urandom); b = DW'($urandom);
    kc(1, 4'd5, 1, 4'd5, a, '0, b, '0);
    kc(1, 4'd5, 1, 4'd5, b, 2'b10, a, 2'b01);
    kc(1, 4'd5, 0, 0, 0, '1, 0, '1);
    nop(2);
    // R5: lane masks per word
    cur_tag = "R5";
    kc(0, 0, 1, 4'd7, 18'h3FFFF, 2'b01, 18'h00000, 2'b10);
    kc(1, 4'd7, 0, 0, 0, '1, 0, '1);
    kc(0, 0, 1, 4'd7, 18'h12345, 2'b11, 18'h2ABCD, 2'b11);
    kc(1, 4'd7, 0, 0, 0, '1, 0, '1);
    nop(2);
    // R11: deselected write with garbage on the buses
    cur_tag = "R11";
    rd_sel_n = 1'b1;
    kc(0, 4'd9, 0, 4'd9, 18'h3FFFF, '0, 18'h3FFFF, '0);
    kc(1, 4'd9, 0, 0, 0, '1, 0, '1);
    // R10: concurrent read and write on different addresses
    cur_tag = "R10";
    kc(1, 4'd2, 1, 4'd3, 18'h11111, '0, 18'h22222, '0);
    kc(1, 4'd3, 1, 4'd2, 18'h33333, '0, 18'h04444, '0);
    kc(1, 4'd2, 0, 0, 0, '1, 0, '1);
    // R4: back-to-back reads, unbroken stream
    cur_tag = "R4";
    for (int i = 0; i < 6; i++) kc(1, AW'(i), 0, 0, 0, '1, 0, '1);
    // R9: idle after reads stop
    cur_tag = "R9";
    nop(3);
    // random mix on a few addresses so hits are frequent; latency tag R6 or R7
    cur_tag = leg ? "R7" : "R6";
    for (int i = 0; i < 300; i++) begin
      bit rd, wr;
      rd = 1'($urandom); wr = 1'($urandom);
      kc(rd, AW'($urandom % 4), wr, AW'($urandom % 4), DW'($urandom),
         LANES'($urandom), DW'($urandom), LANES'($urandom));
    end
    nop(4);
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule